// File: doc/BRIEF.md
# E1 National Bit Overhead Inserter

This block sits in the transmit path of an E1 framer. It sees the outgoing bit stream one bit slot at a time, together with a position counter that gives the frame parity, the timeslot and the bit position. It replaces the National (Sa4 to Sa8) bits of timeslot 0 in frames that carry no frame alignment signal with data link bits. Every other bit goes through unchanged. The stream leaves the block one bit slot later than it arrives.

Each of the five Sa positions is configured on its own. A position can be disabled, in which case it carries a fixed fill value. It can be fed from an internal HDLC controller port, or fed from an external serial device. For the external case the block drives a gapped overhead clock, `oh_clk`, with one pulse per external Sa slot. The device changes `oh_data` after the rising edge, and the block latches it at the falling edge.

The control state machine has six states:
- `ST_WAIT_ALIGN` is the state after reset, with no substitution.
- `ST_PASS` is a slot that is not an Sa slot.
- `ST_SA_FILL` is a disabled Sa slot.
- `ST_SA_HDLC` is an Sa slot fed from the HDLC port.
- `ST_EXT_HIGH` is the first half of an external Sa slot, with the clock high.
- `ST_EXT_LOW` is the second half of an external Sa slot, with the clock low.

The transitions are as follows:
- The machine leaves `ST_WAIT_ALIGN` on the first strobe that marks bit 1 of timeslot 0 in an alignment frame.
- In every aligned state, a strobe moves the machine to the state that matches the incoming slot's class.
- `ST_EXT_HIGH` falls through to `ST_EXT_LOW` once half the bit period has elapsed. The falling-edge capture happens on that transition.

Top module: `e1_sa_inserter`

## Requirements
- R1: While reset is asserted and just after it, `oh_clk` is 0, `hdlc_take` is 0, `tx_bit_valid` is 0 and `tx_bit_out` is 1.
- R2: Before the first alignment point, every bit passes unchanged, `oh_clk` stays low and `hdlc_take` stays low, whatever the Sa configuration.
- R3: Alignment is reached on a strobe with `nfas_frame`=0, `ts_idx`=0 and `bit_pos`=0. From the next non-alignment frame on, substitution takes place.
- R4: In each aligned non-alignment frame, `oh_clk` gives exactly popcount(`sa_enable` & ~`sa_from_hdlc`) pulses.
- R5: For an external Sa slot, `oh_clk` rises on the clock edge that takes the slot's strobe. It stays high for BIT_CLKS/2 cycles, then stays low for the rest of the slot.
- R6: The bit inserted into an external Sa slot is the value of `oh_data` at the edge where `oh_clk` falls.
- R7: Each strobe edge loads `tx_bit_out` with the result for the previous slot, and `tx_bit_valid` pulses for one cycle after it. `tx_bit_out` holds steady between strobes. There is no valid pulse on the first strobe after reset.
- R8: Bits outside the Sa slots are output equal to their input: bit positions 0 to 2 of timeslot 0, all other timeslots, and all of every alignment frame.
- R9: An enabled Sa slot with its `sa_from_hdlc` bit set outputs `hdlc_bit` as sampled at that slot's strobe. `hdlc_take` is high in exactly that strobe cycle.
- R10: A disabled Sa slot outputs its `sa_fill` bit and produces neither a clock pulse nor an HDLC take.
- R11: Bit k of `sa_enable`, `sa_from_hdlc` and `sa_fill` controls Sa(4+k), which sits at `bit_pos`=3+k of timeslot 0. `bit_pos` 0 is the first bit of the timeslot. Non-external slots produce no clock pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_stb | input | 1 | One-cycle strobe at the start of each bit slot, every BIT_CLKS cycles |
| nfas_frame | input | 1 | 1 when the current frame carries no frame alignment signal |
| ts_idx | input | TS_W | Timeslot of the current bit |
| bit_pos | input | POS_W | Bit position within the timeslot, 0 first |
| tx_bit_in | input | 1 | Incoming transmit bit, valid with the strobe |
| sa_enable | input | SA_N | Per-Sa enable for data link carriage |
| sa_from_hdlc | input | SA_N | Per-Sa source select, 1 for the internal HDLC port |
| sa_fill | input | SA_N | Per-Sa value for disabled positions |
| hdlc_bit | input | 1 | Data bit from the HDLC controller |
| hdlc_take | output | 1 | The HDLC bit is consumed in this strobe cycle |
| oh_clk | output | 1 | Gapped overhead clock to the external device |
| oh_data | input | 1 | Serial data from the external device |
| tx_bit_out | output | 1 | Outgoing transmit bit, one slot late |
| tx_bit_valid | output | 1 | One-cycle pulse when `tx_bit_out` is updated |

## Verification
The bench first drives full non-alignment frames before any alignment point. A design that substitutes too early, or pulses the clock from reset, shows extra pulses or altered Sa bits there. The external device holds its data constant only across the capture window and changes it in non-external slots. A design that samples on the wrong edge or in the wrong slot therefore inserts the wrong bit. The mixed configuration has disabled, HDLC-fed and externally fed positions side by side. It exposes a reversed mask mapping, a swapped source select or a missing fill, because pulse counts, take strobes and output bits all move to the wrong Sa positions.

// File: rtl/e1sa_pkg.sv
package e1sa_pkg;

    typedef enum logic [2:0] {
        ST_WAIT_ALIGN,
        ST_PASS,
        ST_SA_FILL,
        ST_SA_HDLC,
        ST_EXT_HIGH,
        ST_EXT_LOW
    } oh_state_t;

    typedef enum logic [1:0] {
        SLOT_PASS,
        SLOT_FILL,
        SLOT_HDLC,
        SLOT_EXT
    } slot_kind_t;

endpackage

// File: rtl/e1sa_slot_classify.sv
module e1sa_slot_classify
    import e1sa_pkg::*;
#(
    parameter int TS_W     = 5,
    parameter int POS_W    = 3,
    parameter int SA_N     = 5,
    parameter int SA_FIRST = 3
) (
    input  logic             nfas_frame,
    input  logic [TS_W-1:0]  ts_idx,
    input  logic [POS_W-1:0] bit_pos,
    input  logic [SA_N-1:0]  sa_enable,
    input  logic [SA_N-1:0]  sa_from_hdlc,
    input  logic [SA_N-1:0]  sa_fill,
    output slot_kind_t       kind,
    output logic             fill_bit,
    output logic             align_mark
);

    logic [SA_N-1:0] hit;
    logic            ts_zero;

    assign ts_zero    = (ts_idx == '0);
    assign align_mark = !nfas_frame && ts_zero && (bit_pos == '0);

    // One decode per Sa position: bit k of the masks maps to position SA_FIRST+k (R11)
    for (genvar k = 0; k < SA_N; k++) begin : g_sa_hit
        assign hit[k] = nfas_frame && ts_zero && (bit_pos == POS_W'(SA_FIRST + k));
    end

    always_comb begin
        fill_bit = |(hit & ~sa_enable & sa_fill);
        if ((hit & sa_enable & ~sa_from_hdlc) != '0) begin
            kind = SLOT_EXT;
        end else if ((hit & sa_enable & sa_from_hdlc) != '0) begin
            kind = SLOT_HDLC;
        end else if (hit != '0) begin
            kind = SLOT_FILL;
        end else begin
            kind = SLOT_PASS;
        end
    end

endmodule

// File: rtl/e1sa_oh_fsm.sv
module e1sa_oh_fsm
    import e1sa_pkg::*;
#(
    parameter int BIT_CLKS = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       align_mark,
    input  slot_kind_t kind,
    output logic       oh_clk,
    output logic       hdlc_take,
    output logic       cap_fire,
    output slot_kind_t eff_kind
);

    localparam int HALF = BIT_CLKS / 2;
    localparam int PH_W = (BIT_CLKS > 2) ? $clog2(BIT_CLKS) : 1;

    oh_state_t       state, state_nxt;
    logic [PH_W-1:0] phase;
    logic            live;
    logic            half_done;

    function automatic oh_state_t state_of(input slot_kind_t k);
        unique case (k)
            SLOT_FILL: state_of = ST_SA_FILL;
            SLOT_HDLC: state_of = ST_SA_HDLC;
            SLOT_EXT:  state_of = ST_EXT_HIGH;
            default:   state_of = ST_PASS;
        endcase
    endfunction

    assign half_done = (phase == PH_W'(HALF - 1));

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_WAIT_ALIGN: begin
                if (bit_stb && align_mark) state_nxt = state_of(kind);
            end
            ST_EXT_HIGH: begin
                if (bit_stb)        state_nxt = state_of(kind);
                else if (half_done) state_nxt = ST_EXT_LOW;
            end
            ST_PASS, ST_SA_FILL, ST_SA_HDLC, ST_EXT_LOW: begin
                if (bit_stb) state_nxt = state_of(kind);
            end
            default: state_nxt = ST_WAIT_ALIGN;
        endcase
    end

    // State register with the in-slot phase counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_WAIT_ALIGN;
            phase <= '0;
        end else begin
            state <= state_nxt;
            if (bit_stb)          phase <= '0;
            else if (!half_done)  phase <= phase + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        live      = (state != ST_WAIT_ALIGN) || (bit_stb && align_mark);
        eff_kind  = live ? kind : SLOT_PASS;
        oh_clk    = (state == ST_EXT_HIGH);
        hdlc_take = bit_stb && (eff_kind == SLOT_HDLC);
        cap_fire  = (state == ST_EXT_HIGH) && half_done && !bit_stb;
    end

    logic [PH_W:0] hi_len;
    logic          seen_align;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len     <= '0;
            seen_align <= 1'b0;
        end else begin
            hi_len <= oh_clk ? hi_len + 1'b1 : '0;
            if (bit_stb && align_mark) seen_align <= 1'b1;
        end
    end

    assert_rise_on_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oh_clk) |-> $past(bit_stb));

    assert_high_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oh_clk) |-> (hi_len == (PH_W+1)'(HALF)));

    assert_quiet_before_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_align |-> !oh_clk);

endmodule

// File: rtl/e1sa_out_stage.sv
module e1sa_out_stage
    import e1sa_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  slot_kind_t eff_kind,
    input  logic       tx_bit_in,
    input  logic       hdlc_bit,
    input  logic       fill_bit,
    input  logic       cap_fire,
    input  logic       oh_data,
    output logic       tx_bit_out,
    output logic       tx_bit_valid
);

    logic held_bit;
    logic primed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            held_bit     <= 1'b1;
            primed       <= 1'b0;
            tx_bit_out   <= 1'b1;
            tx_bit_valid <= 1'b0;
        end else begin
            tx_bit_valid <= bit_stb && primed;
            if (bit_stb) begin
                tx_bit_out <= held_bit;
                primed     <= 1'b1;
                unique case (eff_kind)
                    SLOT_FILL: held_bit <= fill_bit;
                    SLOT_HDLC: held_bit <= hdlc_bit;
                    default:   held_bit <= tx_bit_in;
                endcase
            end else if (cap_fire) begin
                held_bit <= oh_data;
            end
        end
    end

    assert_valid_after_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_bit_valid |-> $past(bit_stb));

    assert_hold_between_strobes_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(bit_stb) |-> $stable(tx_bit_out));

endmodule

// File: rtl/e1_sa_inserter.sv
module e1_sa_inserter
    import e1sa_pkg::*;
#(
    parameter int BIT_CLKS = 8,
    parameter int TS_W     = 5,
    parameter int POS_W    = 3,
    parameter int SA_N     = 5,
    parameter int SA_FIRST = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bit_stb,
    input  logic             nfas_frame,
    input  logic [TS_W-1:0]  ts_idx,
    input  logic [POS_W-1:0] bit_pos,
    input  logic             tx_bit_in,
    input  logic [SA_N-1:0]  sa_enable,
    input  logic [SA_N-1:0]  sa_from_hdlc,
    input  logic [SA_N-1:0]  sa_fill,
    input  logic             hdlc_bit,
    output logic             hdlc_take,
    output logic             oh_clk,
    input  logic             oh_data,
    output logic             tx_bit_out,
    output logic             tx_bit_valid
);

    slot_kind_t kind, eff_kind;
    logic       fill_bit, align_mark, cap_fire;

    e1sa_slot_classify #(
        .TS_W(TS_W), .POS_W(POS_W), .SA_N(SA_N), .SA_FIRST(SA_FIRST)
    ) u_classify (
        .nfas_frame  (nfas_frame),
        .ts_idx      (ts_idx),
        .bit_pos     (bit_pos),
        .sa_enable   (sa_enable),
        .sa_from_hdlc(sa_from_hdlc),
        .sa_fill     (sa_fill),
        .kind        (kind),
        .fill_bit    (fill_bit),
        .align_mark  (align_mark)
    );

    e1sa_oh_fsm #(.BIT_CLKS(BIT_CLKS)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .align_mark(align_mark),
        .kind      (kind),
        .oh_clk    (oh_clk),
        .hdlc_take (hdlc_take),
        .cap_fire  (cap_fire),
        .eff_kind  (eff_kind)
    );

    e1sa_out_stage u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .bit_stb     (bit_stb),
        .eff_kind    (eff_kind),
        .tx_bit_in   (tx_bit_in),
        .hdlc_bit    (hdlc_bit),
        .fill_bit    (fill_bit),
        .cap_fire    (cap_fire),
        .oh_data     (oh_data),
        .tx_bit_out  (tx_bit_out),
        .tx_bit_valid(tx_bit_valid)
    );

    assert_take_not_external_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hdlc_take |=> !oh_clk);

endmodule

// File: tb/e1_sa_inserter_test.sv
`timescale 1ns/1ps
module e1_sa_inserter_test;

    localparam int BIT_CLKS = 8;
    localparam int HALF     = BIT_CLKS / 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       nfas_frame = 1'b0;
    logic [4:0] ts_idx = '0;
    logic [2:0] bit_pos = '0;
    logic       tx_bit_in = 1'b0;
    logic [4:0] sa_enable = '0, sa_from_hdlc = '0, sa_fill = '1;
    logic       hdlc_bit = 1'b0;
    logic       oh_data = 1'b0;
    logic       hdlc_take, oh_clk, tx_bit_out, tx_bit_valid;

    always #2 clk = ~clk;

    e1_sa_inserter #(.BIT_CLKS(BIT_CLKS)) uut (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .nfas_frame(nfas_frame),
        .ts_idx(ts_idx), .bit_pos(bit_pos), .tx_bit_in(tx_bit_in),
        .sa_enable(sa_enable), .sa_from_hdlc(sa_from_hdlc), .sa_fill(sa_fill),
        .hdlc_bit(hdlc_bit), .hdlc_take(hdlc_take), .oh_clk(oh_clk),
        .oh_data(oh_data), .tx_bit_out(tx_bit_out), .tx_bit_valid(tx_bit_valid)
    );

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    bit          aligned_b, primed_b, exp_prev;
    string       prev_req;
    logic [15:0] dl = 16'hACE1, el = 16'h1F35, hl = 16'h7B29;

    function automatic logic [15:0] step(input logic [15:0] x);
        return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        rst_n = 1'b0; bit_stb = 1'b0; oh_data = 1'b0;
        repeat (3) @(negedge clk);
        check(oh_clk == 0, "R1", "oh_clk in reset", oh_clk, 0);
        check(tx_bit_valid == 0 && hdlc_take == 0, "R1", "valid/take in reset",
              {tx_bit_valid, hdlc_take}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_bit_out == 1, "R1", "tx_bit_out after reset", tx_bit_out, 1);
        aligned_b = 0; primed_b = 0; prev_req = "R8";
    endtask

    task automatic drive_slot(input bit nf, input int ts, input int pos, inout int pulses);
        bit din, hb, eb, sa, ext_s, hdlc_s, expv, clk_bad;
        int k;
        din = dl[0]; dl = step(dl);
        hb  = hl[0];
        eb  = el[0];
        if (!nf && ts == 0 && pos == 0) aligned_b = 1;
        sa = aligned_b && nf && ts == 0 && pos >= 3;
        k  = sa ? pos - 3 : 0;
        ext_s  = sa && sa_enable[k] && !sa_from_hdlc[k];
        hdlc_s = sa && sa_enable[k] &&  sa_from_hdlc[k];
        if (!sa)                 expv = din;
        else if (!sa_enable[k])  expv = sa_fill[k];
        else if (sa_from_hdlc[k]) expv = hb;
        else                     expv = eb;
        if (hdlc_s) hl = step(hl);
        if (ext_s)  el = step(el);
        bit_stb = 1'b1; nfas_frame = nf; ts_idx = 5'(ts); bit_pos = 3'(pos);
        tx_bit_in = din; hdlc_bit = hb;
        if (!ext_s) oh_data = dl[1];
        #1;
        check(hdlc_take == hdlc_s, hdlc_s ? "R9" : (sa ? "R10" : "R2"),
              "hdlc_take", hdlc_take, hdlc_s);
        @(negedge clk);
        bit_stb = 1'b0;
        check(tx_bit_valid == primed_b, "R7", "valid pulse", tx_bit_valid, primed_b);
        if (primed_b)
            check(tx_bit_out == exp_prev, prev_req, "output bit", tx_bit_out, exp_prev);
        clk_bad = 0;
        for (int i = 0; i < BIT_CLKS; i++) begin
            if (i > 0) @(negedge clk);
            if (oh_clk != (ext_s && i < HALF)) clk_bad = 1;
            if (i == 0 && oh_clk) begin
                pulses++;
                oh_data = eb;
            end
        end
        check(!clk_bad, ext_s ? "R5" : "R11", "oh_clk shape in slot", clk_bad, 0);
        exp_prev = expv; primed_b = 1;
        if (!sa)                  prev_req = aligned_b ? "R8" : "R2";
        else if (!sa_enable[k])   prev_req = "R10";
        else if (sa_from_hdlc[k]) prev_req = "R9";
        else                      prev_req = "R6";
    endtask

    task automatic drive_frame(input bit nf, output int pulses);
        bit was_aligned;
        int p = 0;
        was_aligned = aligned_b;
        for (int ts = 0; ts < 32; ts++)
            for (int pos = 0; pos < 8; pos++)
                drive_slot(nf, ts, pos, p);
        if (nf) begin
            int exp_p;
            exp_p = was_aligned ? $countones(sa_enable & ~sa_from_hdlc) : 0;
            check(p == exp_p, was_aligned ? "R4" : "R2", "pulses per frame", p, exp_p);
        end
        pulses = p;
    endtask

    task automatic test_reset();
        apply_reset();
    endtask

    task automatic test_prealign();
        int p;
        apply_reset();
        sa_enable = 5'b11111; sa_from_hdlc = 5'b00000; sa_fill = 5'b00000;
        drive_frame(1, p);
        drive_frame(0, p);
        drive_frame(1, p);
        check(p == 5, "R3", "substitution starts after alignment", p, 5);
    endtask

    task automatic test_external();
        int p;
        apply_reset();
        sa_enable = 5'b11111; sa_from_hdlc = 5'b00000; sa_fill = 5'b00000;
        for (int f = 0; f < 4; f++) drive_frame(f[0], p);
    endtask

    task automatic test_mixed();
        int p;
        apply_reset();
        sa_enable = 5'b10110; sa_from_hdlc = 5'b00100; sa_fill = 5'b01001;
        for (int f = 0; f < 4; f++) drive_frame(f[0], p);
        sa_enable = 5'b01101; sa_from_hdlc = 5'b01000; sa_fill = 5'b10010;
        for (int f = 0; f < 2; f++) drive_frame(f[0], p);
    endtask

    task automatic test_fill_only();
        int p;
        apply_reset();
        sa_enable = 5'b00000; sa_from_hdlc = 5'b11111; sa_fill = 5'b10101;
        for (int f = 0; f < 2; f++) drive_frame(f[0], p);
        check(p == 0, "R10", "no pulses with all disabled", p, 0);
    endtask

    initial begin
        test_reset();
        test_prealign();
        test_external();
        test_mixed();
        test_fill_only();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule